// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM's contents alive and brings the device up correctly after reset. After reset it holds the strobes inactive for a power-up pause. It then runs a burst of wake-up cycles, and after that it issues CAS-before-RAS refresh cycles at a fixed rate. In a CAS-before-RAS cycle the DRAM's own row counter picks the row, so the block drives no address and no data.

The block shares the RAS and CAS lines with an access sequencer. When a refresh is owed, the block raises `req_o`. The sequencer answers with `gnt_i` once it has parked both strobes high, and keeps `gnt_i` high until `req_o` drops. Refreshes the sequencer has not yet serviced are counted as a backlog. `urgent_o` tells the sequencer that the backlog has reached its limit. If one more refresh falls due on a full backlog, the retention deadline is treated as missed: `overrun_o` is set and stays set, normal access is withdrawn, and the wake-up burst runs again. All times are parameters counted in controller clocks.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o` and `cas_n_o` are 1, and `req_o`, `init_done_o`, `urgent_o` and `overrun_o` are 0.
- R2: After reset is released, `req_o` stays 0 and both strobes stay high for the power-up pause. `req_o` rises at the PAUSE_CYC-th rising clock edge after release.
- R3: A strobe leaves its idle-high state only after `gnt_i` was high in the clock before. `req_o` stays high for as long as either strobe is low. While `gnt_i` is low, both strobes stay high.
- R4: Every cycle the block drives is CAS-before-RAS. The strobes pass through four states, given as the pair {RAS, CAS} with 1 meaning high:
  - {1,0} for exactly T_CSR clocks;
  - {0,0} for exactly T_CHR clocks;
  - {0,1} for exactly T_RAS-T_CHR clocks;
  - {1,1} for at least T_RP clocks before CAS falls again.
  RAS never falls while CAS is high.
- R5: After the pause, with the grant held, exactly WAKE_CNT cycles are issued. `init_done_o` rises, and `req_o` falls, in the clock in which the last cycle's precharge ends.
- R6: In normal operation one refresh falls due every REF_INTERVAL clocks, counted from the rise of `init_done_o`. With no backlog, `req_o` rises REF_INTERVAL clocks after `init_done_o` rises.
- R7: While the grant is held, owed refreshes are issued back to back. The number of cycles issued before `req_o` drops equals the number owed.
- R8: `urgent_o` is 1 exactly when the backlog has reached MAX_OWED.
- R9: A refresh that falls due while MAX_OWED are already owed has the following effects:
  - `overrun_o` is set and stays set until reset;
  - `init_done_o` drops;
  - the backlog is cleared;
  - a new burst of WAKE_CNT cycles runs, after which `init_done_o` rises again.
- R10: `init_done_o` is 0 throughout the power-up pause and throughout every wake-up burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | controller clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| gnt_i | input | 1 | strobe ownership granted by the access sequencer |
| req_o | output | 1 | request for strobe ownership |
| urgent_o | output | 1 | backlog at its limit, grant needed now |
| ras_n_o | output | 1 | row strobe, active low |
| cas_n_o | output | 1 | column strobe, active low |
| init_done_o | output | 1 | pause and wake-up burst complete, normal access allowed |
| overrun_o | output | 1 | sticky flag, refresh deadline missed |

## Verification
The hardest state to reach is the deadline overrun. It needs a full backlog followed by one more due refresh, and that takes several refresh intervals in which the sequencer withholds the grant. The bench aligns itself to a rising `req_o` and withholds `gnt_i` for a counted number of clocks. With this it builds backlogs of one, two and three, staying clear of interval boundaries, and then pushes one interval past the limit. A monitor measures every strobe phase at the pins, so the shape of the recovery burst is checked as well as its count.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CSR,
    PH_CHR,
    PH_RASL,
    PH_RP
  } phase_t;

  typedef enum logic [1:0] {
    M_PAUSE,
    M_WAKE,
    M_RUN
  } mode_t;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R6
endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int MAX_OWED = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o,
  output logic full_o,
  output logic ovf_o
);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] LIM = OW'(MAX_OWED);

  logic [OW-1:0] owed_q;

  assign pend_o = (owed_q != '0);
  assign full_o = (owed_q >= LIM);
  assign ovf_o  = inc_i && !dec_i && (owed_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        owed_q <= '0;
    else if (clr_i || ovf_o)            owed_q <= '0;
    else if (inc_i && !dec_i)           owed_q <= owed_q + 1'b1;
    else if (dec_i && !inc_i && pend_o) owed_q <= owed_q - 1'b1;
  end

  AST_OWED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= LIM); // R8
  AST_DEC_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i) |-> pend_o); // R7
endmodule

// File: rtl/dram_ref_cycle.sv
module dram_ref_cycle
  import dram_ref_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_RAS = 3,
  parameter int T_RP  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic done_o
);
  localparam int T_RASL = T_RAS - T_CHR;
  localparam int M1 = (T_CSR > T_CHR) ? T_CSR : T_CHR;
  localparam int M2 = (T_RASL > T_RP) ? T_RASL : T_RP;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXT + 1);

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;

  assign cas_n_o = !((ph_q == PH_CSR) || (ph_q == PH_CHR));
  assign ras_n_o = !((ph_q == PH_CHR) || (ph_q == PH_RASL));
  assign busy_o  = (ph_q != PH_IDLE);
  assign done_o  = (ph_q == PH_RP) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_q  <= PH_CSR;
        cnt_q <= CW'(T_CSR - 1);
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      unique case (ph_q)
        PH_CSR:  begin ph_q <= PH_CHR;  cnt_q <= CW'(T_CHR - 1);  end
        PH_CHR:  begin ph_q <= PH_RASL; cnt_q <= CW'(T_RASL - 1); end
        PH_RASL: begin ph_q <= PH_RP;   cnt_q <= CW'(T_RP - 1);   end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  AST_RAS_NEEDS_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o)); // R4
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R3
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC    = 10000,
  parameter int REF_INTERVAL = 780,
  parameter int WAKE_CNT     = 8,
  parameter int MAX_OWED     = 4,
  parameter int T_CSR        = 1,
  parameter int T_CHR        = 1,
  parameter int T_RAS        = 3,
  parameter int T_RP         = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  output logic req_o,
  output logic urgent_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic init_done_o,
  output logic overrun_o
);
  localparam int WW = $clog2(WAKE_CNT + 1);
  localparam logic [WW-1:0] WAKE_LOAD = WW'(WAKE_CNT);

  mode_t         mode_q;
  logic [WW-1:0] wake_left_q;
  logic          ovr_q;
  logic          pause_end, due_tick, pend, full, ovf;
  logic          busy, done, need, start;

  dram_ref_timer #(.INTERVAL(PAUSE_CYC)) u_pause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode_q == M_PAUSE),
    .tick_o (pause_end)
  );

  dram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_due (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode_q == M_RUN),
    .tick_o (due_tick)
  );

  dram_ref_backlog #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mode_q != M_RUN),
    .inc_i  (due_tick),
    .dec_i  (done && (mode_q == M_RUN)),
    .pend_o (pend),
    .full_o (full),
    .ovf_o  (ovf)
  );

  dram_ref_cycle #(
    .T_CSR (T_CSR),
    .T_CHR (T_CHR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP)
  ) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_comb begin
    unique case (mode_q)
      M_WAKE:  need = (wake_left_q != '0);
      M_RUN:   need = pend;
      default: need = 1'b0;
    endcase
  end

  assign start       = need && gnt_i && !busy;
  assign req_o       = need || busy;
  assign urgent_o    = (mode_q == M_RUN) && full;
  assign init_done_o = (mode_q == M_RUN);
  assign overrun_o   = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= M_PAUSE;
      wake_left_q <= '0;
      ovr_q       <= 1'b0;
    end else begin
      unique case (mode_q)
        M_PAUSE: if (pause_end) begin
          mode_q      <= M_WAKE;
          wake_left_q <= WAKE_LOAD;
        end
        M_WAKE: if (done && (wake_left_q != '0)) begin
          wake_left_q <= wake_left_q - 1'b1;
          if (wake_left_q == WW'(1)) mode_q <= M_RUN;
        end
        M_RUN: if (ovf) begin
          mode_q      <= M_WAKE;
          wake_left_q <= WAKE_LOAD;
          ovr_q       <= 1'b1;
        end
        default: mode_q <= M_PAUSE;
      endcase
    end
  end

  AST_GNT_BEFORE_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> $past(gnt_i)); // R3
  AST_REQ_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> req_o); // R3
  AST_INIT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_done_o) |-> overrun_o); // R9
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(overrun_o) |-> overrun_o); // R9
  AST_WAKE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_left_q <= WAKE_LOAD); // R5
endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int PAUSE = 50;
  localparam int RI    = 40;
  localparam int WAKE  = 8;
  localparam int MAXO  = 3;
  localparam int TCSR  = 2;
  localparam int TCHR  = 2;
  localparam int TRAS  = 5;
  localparam int TRP   = 3;
  localparam int WD_LIMIT = 20000;

  // hold-off clocks after req rise, expected cycles issued, expected urgent
  localparam int NV = 3;
  localparam int HOLD [NV] = '{5, 45, 82};
  localparam int EXPN [NV] = '{1, 2, 3};
  localparam int EXPU [NV] = '{0, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, urgent, ras_n, cas_n, init_done, overrun;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int falls = 0;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .REF_INTERVAL(RI), .WAKE_CNT(WAKE), .MAX_OWED(MAXO),
    .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .req_o(req), .urgent_o(urgent),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .init_done_o(init_done), .overrun_o(overrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  // strobe shape monitor, pair is {ras_n, cas_n}
  logic [1:0] prev = 2'b11;
  int run = 1000;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] cur;
      cur = {ras_n, cas_n};
      if (cur != prev) begin
        case (prev)
          2'b10: chk(run == TCSR && cur == 2'b00, "R4 cas lead", run, TCSR);
          2'b00: chk(run == TCHR && cur == 2'b01, "R4 both low", run, TCHR);
          2'b01: chk(run == TRAS - TCHR && cur == 2'b11, "R4 ras tail", run, TRAS - TCHR);
          default: chk(run >= TRP && cur == 2'b10, "R4 precharge", run, TRP);
        endcase
        if (cur == 2'b00) falls++;
        run = 1;
      end else begin
        run++;
      end
      if (cur != 2'b11) chk(req == 1'b1, "R3 req held", req, 1);
      prev = cur;
    end
  end

  initial begin
    int n;
    int f0;
    bit ok;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n, "R1 strobes", {ras_n, cas_n}, 3);
    chk(!req && !init_done, "R1 req/init", {req, init_done}, 0);
    chk(!urgent && !overrun, "R1 urgent/overrun", {urgent, overrun}, 0);
    rst_n = 1'b1;

    n = 0;
    ok = 1;
    while (!req && n < 1000) begin
      @(negedge clk);
      n++;
      if (init_done) ok = 0;
    end
    chk(n == PAUSE, "R2 pause length", n, PAUSE);
    chk(ok, "R10 init low in pause", ok, 1);

    ok = 1;
    repeat (15) begin
      @(negedge clk);
      if (!ras_n || !cas_n || !req) ok = 0;
    end
    chk(ok, "R3 no cycle without grant", ok, 1);

    gnt = 1'b1;
    f0 = falls;
    ok = 1;
    n = 0;
    while (!init_done && n < 1000) begin
      @(negedge clk);
      n++;
      if (!init_done && !req) ok = 0;
    end
    chk(falls - f0 == WAKE, "R5 wake count", falls - f0, WAKE);
    chk(req == 1'b0, "R5 req drops", req, 0);
    chk(ok, "R10 req held through burst", ok, 1);
    gnt = 1'b0;

    n = 0;
    while (!req && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == RI, "R6 first due", n, RI);

    for (int v = 0; v < NV; v++) begin
      n = 0;
      while (!req && n < 1000) begin
        @(negedge clk);
        n++;
      end
      repeat (HOLD[v]) @(negedge clk);
      chk(urgent == EXPU[v][0], "R8 urgent level", urgent, EXPU[v]);
      gnt = 1'b1;
      f0 = falls;
      n = 0;
      while (req && n < 1000) begin
        @(negedge clk);
        n++;
      end
      chk(falls - f0 == EXPN[v], "R7 backlog drained", falls - f0, EXPN[v]);
      gnt = 1'b0;
    end

    n = 0;
    while (!req && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (RI * MAXO - 1) @(negedge clk);
    chk(urgent == 1'b1, "R8 urgent at limit", urgent, 1);
    chk(overrun == 1'b0 && init_done == 1'b1, "R9 before deadline", {overrun, init_done}, 1);
    repeat (2) @(negedge clk);
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    chk(init_done == 1'b0, "R9 init dropped", init_done, 0);
    chk(urgent == 1'b0, "R9 backlog cleared", urgent, 0);
    chk(req == 1'b1, "R9 wake requested", req, 1);

    gnt = 1'b1;
    f0 = falls;
    n = 0;
    while (!init_done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(falls - f0 == WAKE, "R9 rewake count", falls - f0, WAKE);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    gnt = 1'b0;
    repeat (5) @(negedge clk);

    summary();
    $finish;
  end
endmodule